// File: doc/BRIEF.md
# Region-Based I/O Wait-State Generator

This block runs accesses to a separate I/O space of 2048 locations, reached only by dedicated I/O read and write operations. A CPU-side request carries an 11-bit location, a direction and write data. The block latches the request, drives the location onto the low bits of the external address bus and pulls an active-low I/O select. It then stretches the access by a number of wait states that it inserts without any handshake from the peripheral. The CPU sees a ready pulse on the last cycle of the access, and read data passes straight through from the external bus in that cycle.

The I/O space is split into four equal regions of 512 locations, chosen by address bits 10:9. Each region has its own 3-bit wait count, from 0 to 7, written through its own write-enable port. All four counts reset to 7, the slowest setting, so that slow peripherals work before software has set the counts. The external address bits above bit 10 carry no meaning for I/O and are driven to zero.

Top module: `io_region_waiter`

## Requirements
- R1: After reset, extSelN, extWrN and extRdN are 1 and ready is 0. All four wait counts are 7, so the first access to any region holds extSelN low for 8 cycles.
- R2: A request accepted at a clock edge drives extSelN low from that edge for exactly 1 + N cycles, where N is the wait count of the addressed region.
- R3: The wait count is chosen by reqAddr[10:9]. Value 0 selects region 0 (0x000-0x1FF), 1 selects region 1 (0x200-0x3FF), 2 selects region 2 (0x400-0x5FF) and 3 selects region 3 (0x600-0x7FF).
- R4: ready is 1 in exactly one cycle of each access, the last cycle in which extSelN is low. It is never 1 while extSelN is high.
- R5: Throughout an access, extAddr[10:0] equals the latched reqAddr and stays stable, and extAddr[13:11] is 0.
- R6: During an access, a write (reqWrite=1) drives extWrN low and presents the latched reqWdata on extDout, and a read drives extRdN low. Outside an access both strobes are 1, and they are never low together.
- R7: reqValid is only sampled while no access is in progress. After every access extSelN is high for at least one cycle before the next access, even if reqValid is held high.
- R8: Writing a region's wait count takes effect from the next accepted request. A write made during an access, or at the same edge that accepts a request, does not change that access's length.
- R9: While ready is 1, rspRdata equals extDin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | CPU requests an I/O access |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 11 | I/O location |
| reqWdata | input | 16 | Write data |
| ready | output | 1 | Last cycle of the current access |
| rspRdata | output | 16 | Read data returned to the CPU |
| cfgWe | input | 4 | One write enable per region wait count |
| cfgWd | input | 12 | Wait counts, 3 bits per region, region k in bits 3k+2:3k |
| extAddr | output | 14 | External address bus |
| extSelN | output | 1 | Active-low I/O select |
| extWrN | output | 1 | Active-low write strobe |
| extRdN | output | 1 | Active-low read strobe |
| extDout | output | 16 | External write data |
| extDin | input | 16 | External read data |

## Verification
The assertions check on every cycle that ready only appears inside a select window and is followed by a high cycle of select. They also check that the address is stable with zeroed upper bits while select is low, that the two strobes never overlap and track select, that an access only starts after a request, and that no window exceeds eight cycles. Only the bench scenarios can show that the window length matches the count of the region picked by bits 10:9. They also cover the reset value of every count, the point from which a rewritten count takes effect, and the correct direction and data for each access.

// File: rtl/io_waiter_pkg.sv
package io_waiter_pkg;
  typedef struct packed {
    logic load;    // accept a request and latch it
    logic step;    // count one wait state down
    logic finish;  // final cycle of the access
  } ctlStrobe_t;
endpackage

// File: rtl/io_waiter_ctrl.sv
module io_waiter_ctrl
  import io_waiter_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       cntZero,
  output ctlStrobe_t strobe,
  output logic       busy
);
  typedef enum logic {ST_IDLE, ST_ACCESS} state_t;
  state_t stateQ, stateD;

  always_comb begin
    strobe.load   = (stateQ == ST_IDLE) && reqValid;
    strobe.step   = (stateQ == ST_ACCESS) && !cntZero;
    strobe.finish = (stateQ == ST_ACCESS) && cntZero;
    stateD = stateQ;
    if (strobe.load)   stateD = ST_ACCESS;
    if (strobe.finish) stateD = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busy = (stateQ == ST_ACCESS);
endmodule

// File: rtl/io_waiter_dp.sv
module io_waiter_dp
  import io_waiter_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int EXT_ADDR_W = 14,
  parameter int DATA_W     = 16,
  parameter int WS_W       = 3,
  parameter int REGIONS    = 4,
  parameter logic [WS_W-1:0] WS_RESET = '1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStrobe_t                strobe,
  input  logic                      busy,
  input  logic                      reqWrite,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [DATA_W-1:0]         reqWdata,
  input  logic [REGIONS-1:0]        cfgWe,
  input  logic [REGIONS*WS_W-1:0]   cfgWd,
  input  logic [DATA_W-1:0]         extDin,
  output logic                      cntZero,
  output logic                      ready,
  output logic [DATA_W-1:0]         rspRdata,
  output logic [EXT_ADDR_W-1:0]     extAddr,
  output logic                      extSelN,
  output logic                      extWrN,
  output logic                      extRdN,
  output logic [DATA_W-1:0]         extDout
);
  localparam int SEL_W = $clog2(REGIONS);
  localparam int PAD_W = EXT_ADDR_W - ADDR_W;

  logic [REGIONS-1:0][WS_W-1:0] waitQ;
  logic [SEL_W-1:0]  regionIdx;
  logic [WS_W-1:0]   countQ;
  logic [ADDR_W-1:0] addrQ;
  logic              writeQ;
  logic [DATA_W-1:0] wdataQ;

  for (genvar g = 0; g < REGIONS; g++) begin : g_wait
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         waitQ[g] <= WS_RESET;
      else if (cfgWe[g]) waitQ[g] <= cfgWd[g*WS_W +: WS_W];
    end
  end

  assign regionIdx = reqAddr[ADDR_W-1 -: SEL_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
      addrQ  <= '0;
      writeQ <= 1'b0;
      wdataQ <= '0;
    end else if (strobe.load) begin
      countQ <= waitQ[regionIdx];
      addrQ  <= reqAddr;
      writeQ <= reqWrite;
      wdataQ <= reqWdata;
    end else if (strobe.step) begin
      countQ <= countQ - 1'b1;
    end
  end

  assign cntZero  = (countQ == '0);
  assign ready    = strobe.finish;
  assign rspRdata = extDin;
  assign extAddr  = {{PAD_W{1'b0}}, addrQ};
  assign extSelN  = ~busy;
  assign extWrN   = ~(busy & writeQ);
  assign extRdN   = ~(busy & ~writeQ);
  assign extDout  = wdataQ;
endmodule

// File: rtl/io_region_waiter.sv
module io_region_waiter
  import io_waiter_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int EXT_ADDR_W = 14,
  parameter int DATA_W     = 16,
  parameter int WS_W       = 3,
  parameter int REGIONS    = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    reqWrite,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [DATA_W-1:0]       reqWdata,
  output logic                    ready,
  output logic [DATA_W-1:0]       rspRdata,
  input  logic [REGIONS-1:0]      cfgWe,
  input  logic [REGIONS*WS_W-1:0] cfgWd,
  output logic [EXT_ADDR_W-1:0]   extAddr,
  output logic                    extSelN,
  output logic                    extWrN,
  output logic                    extRdN,
  output logic [DATA_W-1:0]       extDout,
  input  logic [DATA_W-1:0]       extDin
);
  ctlStrobe_t strobe;
  logic busy;
  logic cntZero;

  io_waiter_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .cntZero(cntZero),
    .strobe(strobe), .busy(busy)
  );

  io_waiter_dp #(
    .ADDR_W(ADDR_W), .EXT_ADDR_W(EXT_ADDR_W), .DATA_W(DATA_W),
    .WS_W(WS_W), .REGIONS(REGIONS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busy(busy),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .cfgWe(cfgWe), .cfgWd(cfgWd), .extDin(extDin),
    .cntZero(cntZero), .ready(ready), .rspRdata(rspRdata),
    .extAddr(extAddr), .extSelN(extSelN), .extWrN(extWrN),
    .extRdN(extRdN), .extDout(extDout)
  );
endmodule

// File: rtl/io_waiter_chk.sv
module io_waiter_chk #(
  parameter int ADDR_W     = 11,
  parameter int EXT_ADDR_W = 14,
  parameter int WS_W       = 3
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  reqValid,
  input logic                  ready,
  input logic [EXT_ADDR_W-1:0] extAddr,
  input logic                  extSelN,
  input logic                  extWrN,
  input logic                  extRdN
);
  localparam int MAX_LEN = 1 << WS_W;
  logic [WS_W:0] lowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        lowCnt <= '0;
    else if (extSelN) lowCnt <= '0;
    else              lowCnt <= lowCnt + 1'b1;
  end

  AST_READY_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> !extSelN); // R4
  AST_GAP_AFTER_READY: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> extSelN); // R7
  AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $fell(extSelN) |-> $past(reqValid)); // R7
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!extSelN && !$past(extSelN)) |-> $stable(extAddr)); // R5
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    extAddr[EXT_ADDR_W-1:ADDR_W] == '0); // R5
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    (extWrN || extRdN) && ((!extWrN || !extRdN) == !extSelN)); // R6
  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    !extSelN |-> (lowCnt < MAX_LEN)); // R2
endmodule

bind io_region_waiter io_waiter_chk #(
  .ADDR_W(ADDR_W), .EXT_ADDR_W(EXT_ADDR_W), .WS_W(WS_W)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .ready(ready),
  .extAddr(extAddr), .extSelN(extSelN), .extWrN(extWrN), .extRdN(extRdN)
);

// File: tb/io_region_waiter_test.sv
module io_region_waiter_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [10:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        ready;
  logic [15:0] rspRdata;
  logic [3:0]  cfgWe = '0;
  logic [11:0] cfgWd = '0;
  logic [13:0] extAddr;
  logic        extSelN, extWrN, extRdN;
  logic [15:0] extDout;
  logic [15:0] extDin = 16'h3C5A;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  io_region_waiter uut (.*);

  // addr[31:21] write[20] data[19:4] len[3:0]
  localparam logic [31:0] VECS [0:7] = '{
    {11'h000, 1'b1, 16'hA5A5, 4'd1},
    {11'h1FF, 1'b0, 16'h0000, 4'd1},
    {11'h200, 1'b1, 16'h1234, 4'd4},
    {11'h3FF, 1'b0, 16'h0000, 4'd4},
    {11'h400, 1'b1, 16'hBEEF, 4'd6},
    {11'h5FF, 1'b0, 16'h0000, 4'd6},
    {11'h600, 1'b0, 16'h0000, 4'd8},
    {11'h7FF, 1'b1, 16'hC0DE, 4'd8}
  };

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setWait(input int k, input logic [2:0] v);
    @(negedge clk);
    cfgWe = 4'b1 << k;
    cfgWd = 12'(v) << (3 * k);
    @(negedge clk);
    cfgWe = '0;
  endtask

  // Issues one request, measures the select window and checks it.
  task automatic runAccess(input logic [10:0] a, input bit w, input logic [15:0] d,
                           input int expLen, input string tag,
                           input int cfgAt = -1, input int cfgK = 0,
                           input logic [2:0] cfgV = 0);
    int len = 0;
    int readyHits = 0;
    bit lastReady = 0;
    bit addrOk = 1;
    bit dirOk = 1;
    bit rdOk = 1;
    @(negedge clk);
    reqValid = 1; reqAddr = a; reqWrite = w; reqWdata = d;
    if (cfgAt == 0) begin cfgWe = 4'b1 << cfgK; cfgWd = 12'(cfgV) << (3 * cfgK); end
    @(negedge clk);
    reqValid = 0; cfgWe = '0;
    while (extSelN == 1'b0 && len < 20) begin
      len++;
      if (cfgAt == len) begin cfgWe = 4'b1 << cfgK; cfgWd = 12'(cfgV) << (3 * cfgK); end
      lastReady = ready;
      if (ready) begin
        readyHits++;
        if (rspRdata !== extDin) rdOk = 0;
      end
      if (extAddr !== {3'b000, a}) addrOk = 0;
      if (w) begin
        if (extWrN !== 1'b0 || extRdN !== 1'b1 || extDout !== d) dirOk = 0;
      end else begin
        if (extRdN !== 1'b0 || extWrN !== 1'b1) dirOk = 0;
      end
      @(negedge clk);
      cfgWe = '0;
    end
    check(len == expLen, {tag, " window length R2/R3"}, len, expLen);
    check(readyHits == 1 && lastReady, {tag, " R4 ready on last cycle"}, readyHits, 1);
    check(addrOk, {tag, " R5 address"}, addrOk, 1);
    check(dirOk, {tag, " R6 direction/data"}, dirOk, 1);
    check(rdOk, {tag, " R9 read data"}, rdOk, 1);
    check(ready === 1'b0 && extWrN === 1'b1 && extRdN === 1'b1, {tag, " R4/R6 idle"},
          ready, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        nChecks++; nFail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        summary();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(extSelN === 1'b1, "R1 select idle", extSelN, 1);
    check(ready === 1'b0, "R1 ready low", ready, 0);
    check(extWrN === 1'b1 && extRdN === 1'b1, "R1 strobes idle", extWrN, 1);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset counts are 7 in every region
    for (int k = 0; k < 4; k++)
      runAccess(11'(k * 512 + 5), 1'b0, 16'h0, 8, "R1 reset count");

    // Program counts 0,3,5,7 and walk the table (R3)
    setWait(0, 3'd0);
    setWait(1, 3'd3);
    setWait(2, 3'd5);
    setWait(3, 3'd7);
    for (int i = 0; i < 8; i++) begin
      logic [31:0] v;
      v = VECS[i];
      runAccess(v[31:21], v[20], v[19:4], int'(v[3:0]), "R3 table");
    end

    // R8: rewrite region 2 in the middle of an access, old length holds
    runAccess(11'h480, 1'b1, 16'h5555, 6, "R8 mid-access write", 3, 2, 3'd1);
    runAccess(11'h480, 1'b0, 16'h0, 2, "R8 new count used");
    // R8: write at the accepting edge uses the old value
    runAccess(11'h090, 1'b0, 16'h0, 1, "R8 same-edge write", 0, 0, 3'd6);
    runAccess(11'h090, 1'b0, 16'h0, 7, "R8 same-edge new count");

    // R7: reqValid held high, region count 1 -> low,low,high repeating
    setWait(0, 3'd1);
    @(negedge clk);
    reqValid = 1; reqAddr = 11'h010; reqWrite = 0;
    @(negedge clk);
    begin
      bit patOk = 1;
      for (int c = 0; c < 9; c++) begin
        if (extSelN !== ((c % 3) == 2)) patOk = 0;
        @(negedge clk);
      end
      check(patOk, "R7 gap between back-to-back accesses", patOk, 1);
    end
    reqValid = 0;
    repeat (3) @(negedge clk);
    check(extSelN === 1'b1, "R7 idle after request drops", extSelN, 1);

    done = 1;
    summary();
  end
endmodule